// File: doc/BRIEF.md
# Integer Multiply-Accumulate Execution Unit

This unit performs the integer multiply and multiply-accumulate work of a 32-bit RISC core. It holds a 64-bit accumulator, which is split into a high half and a low half. Each cycle it can take one R-type instruction word together with the two source operand values that the register file has already read out. It then overwrites the accumulator with the product, or adds the product to it. When the instruction asks for it, the unit also returns the low or the high 32 bits of the updated accumulator for a destination register.

All operations share one function code. A 5-bit secondary code in the shift-amount field chooses three things: signed or unsigned operands, overwrite or accumulate, and low-half or high-half writeback. The register file, hazard handling and doubleword variants belong to the surrounding pipeline.

Top module: `mac_exec_unit`

## Requirements
- R1: An instruction is accepted only when `valid_i` is high, bits 31:26 are 000000 and bits 5:0 are 101000. The secondary code is bits 10:6 and the destination index is bits 15:11. Any other word changes nothing: no accumulator update, no writeback and no illegal flag.
- R2: Codes 00100 and 01100 set the accumulator to the signed product. Both operands are sign-extended to 64 bits before multiplying.
- R3: Codes 00101 and 01101 set the accumulator to the unsigned product. Both operands are zero-extended to 64 bits.
- R4: Codes 00010 and 01010 add the signed product to the accumulator, wrapping modulo 2^64.
- R5: Codes 00011 and 01011 add the unsigned product to the accumulator, wrapping modulo 2^64.
- R6: For codes with bit 3 set (01xxx), `wb_data_o` carries bits 63:32 of the updated accumulator. For the other legal codes it carries bits 31:0.
- R7: Code 00000 with destination 0 adds the signed product to the accumulator and writes no register.
- R8: A legal instruction whose destination index is 0 updates the accumulator but never raises `wb_en_o`.
- R9: Under function 101000, every other code, including 00000 with a nonzero destination, raises `illegal_o` for one cycle. It leaves the accumulator unchanged and raises no writeback.
- R10: The accumulator, the writeback outputs and `illegal_o` take their new values at the clock edge that samples the instruction. `wb_en_o` and `illegal_o` stay high for only that one cycle. With `valid_i` low the accumulator holds and both flags are low.
- R11: A clock edge with `rst_n` low clears the accumulator, `wb_en_o` and `illegal_o`. `hi_o` and `lo_o` always show the two halves of the accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| valid_i | input | 1 | Instruction word and operands are present this cycle |
| instr_i | input | 32 | R-type instruction word |
| rs_val_i | input | 32 | First source operand value |
| rt_val_i | input | 32 | Second source operand value |
| wb_en_o | output | 1 | Destination register write strobe |
| wb_idx_o | output | 5 | Destination register index |
| wb_data_o | output | 32 | Value to write |
| illegal_o | output | 1 | Unrecognised secondary code under the shared function |
| hi_o | output | 32 | Accumulator bits 63:32 |
| lo_o | output | 32 | Accumulator bits 31:0 |

## Verification
The accumulator is visible on `hi_o` and `lo_o` on the cycle right after every edge. A wrong product, a wrong extension mode or a lost carry across the two halves therefore shows up one cycle after the faulty instruction, and it keeps showing on every later cycle until the next overwriting multiply. A decode fault behaves differently. If the unit writes the wrong half, or suppresses or drops the write strobe, the error appears only on the writeback outputs, and only in the single cycle that follows the instruction. Each instruction is therefore checked in exactly that cycle.

// File: rtl/mac_pkg.sv
// Package: shared constants and the decoded control word for the
// multiply-accumulate unit. Assumes 32-bit R-type instruction words.
package mac_pkg;

    localparam logic [5:0] OPC_REG   = 6'b000000;
    localparam logic [5:0] FUNCT_MAC = 6'b101000;
    localparam int         REG_IDX_W = 5;
    localparam int         CODE_W    = 5;

    // Decoded control for one accepted instruction.
    typedef struct packed {
        logic                 act;      // accumulator is updated
        logic                 illegal;  // unknown code under the shared function
        logic                 sgn;      // signed operand extension
        logic                 accum;    // add to accumulator instead of overwrite
        logic                 hi_sel;   // return the upper half
        logic                 wr;       // destination register is written
        logic [REG_IDX_W-1:0] rd;       // destination index
    } mac_ctrl_t;

endpackage

// File: rtl/mac_decode.sv
// Module: mac_decode
// Turns an instruction word into a control word. The secondary code in
// bits 10:6 picks the operation. The decode is purely combinational.
// Assumes the caller qualifies instr_i with valid_i.
module mac_decode
    import mac_pkg::*;
(
    input  logic        valid_i,
    input  logic [31:0] instr_i,
    output mac_ctrl_t   ctrl_o
);

    logic [5:0]           opc;
    logic [5:0]           funct;
    logic [CODE_W-1:0]    code;
    logic [REG_IDX_W-1:0] rd;

    assign opc   = instr_i[31:26];
    assign funct = instr_i[5:0];
    assign code  = instr_i[10:6];
    assign rd    = instr_i[15:11];

    // Classify the code: multiply (x010x), multiply-accumulate (x001x),
    // plain accumulate (00000 with rd 0), otherwise illegal.
    always_comb begin
        ctrl_o    = '0;
        ctrl_o.rd = rd;
        if (valid_i && opc == OPC_REG && funct == FUNCT_MAC) begin
            if (code == 5'b00000 && rd == '0) begin
                ctrl_o.act   = 1'b1;
                ctrl_o.sgn   = 1'b1;
                ctrl_o.accum = 1'b1;
            end else if (!code[4] && (code[2:1] == 2'b10 || code[2:1] == 2'b01)) begin
                ctrl_o.act    = 1'b1;
                ctrl_o.sgn    = !code[0];
                ctrl_o.accum  = code[1];
                ctrl_o.hi_sel = code[3];
                ctrl_o.wr     = (rd != '0);
            end else begin
                ctrl_o.illegal = 1'b1;
            end
        end
    end

endmodule

// File: rtl/mac_accum.sv
// Module: mac_accum
// Multiplier and accumulator register. Operands are extended to twice the
// operand width before the multiply. The sum wraps at that width.
// Assumes ctrl_i.act is asserted only for legal accepted instructions.
module mac_accum
    import mac_pkg::*;
#(
    parameter int XLEN = 32,
    localparam int AW  = 2 * XLEN
) (
    input  logic            clk,
    input  logic            rst_n,
    input  mac_ctrl_t       ctrl_i,
    input  logic [XLEN-1:0] a_i,
    input  logic [XLEN-1:0] b_i,
    output logic [AW-1:0]   acc_next_o,
    output logic [AW-1:0]   acc_o
);

    logic [AW-1:0] a_ext;
    logic [AW-1:0] b_ext;
    logic [AW-1:0] prod;

    // Extend the operands by sign or by zero, as the control word asks.
    always_comb begin
        a_ext = {{XLEN{ctrl_i.sgn & a_i[XLEN-1]}}, a_i};
        b_ext = {{XLEN{ctrl_i.sgn & b_i[XLEN-1]}}, b_i};
        prod  = a_ext * b_ext;
    end

    // Choose overwrite or accumulate.
    always_comb begin
        acc_next_o = ctrl_i.accum ? (acc_o + prod) : prod;
    end

    // Accumulator register with synchronous active-low clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            acc_o <= '0;
        else if (ctrl_i.act)
            acc_o <= acc_next_o;
    end

    // R9 / R10: with no accepted operation, the accumulator holds.
    p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_i.act |=> $stable(acc_o));

    // R2: an overwrite with a zero operand leaves a zero accumulator.
    p_zero_product_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_i.act && !ctrl_i.accum && (a_i == '0 || b_i == '0)) |=> (acc_o == '0));

endmodule

// File: rtl/mac_wb.sv
// Module: mac_wb
// Writeback register stage. It captures the selected half of the new
// accumulator, the destination index, the strobe and the illegal flag.
// Assumes acc_i is the value being loaded into the accumulator this edge.
module mac_wb
    import mac_pkg::*;
#(
    parameter int XLEN = 32,
    localparam int AW  = 2 * XLEN
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  mac_ctrl_t            ctrl_i,
    input  logic [AW-1:0]        acc_i,
    output logic                 wb_en_o,
    output logic [REG_IDX_W-1:0] wb_idx_o,
    output logic [XLEN-1:0]      wb_data_o,
    output logic                 illegal_o
);

    logic [XLEN-1:0] half;

    // Select the half of the new accumulator to return.
    always_comb begin
        half = ctrl_i.hi_sel ? acc_i[AW-1:XLEN] : acc_i[XLEN-1:0];
    end

    // One-cycle strobes; index and data are registered alongside them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_en_o   <= 1'b0;
            illegal_o <= 1'b0;
            wb_idx_o  <= '0;
            wb_data_o <= '0;
        end else begin
            wb_en_o   <= ctrl_i.act & ctrl_i.wr;
            illegal_o <= ctrl_i.illegal;
            wb_idx_o  <= ctrl_i.rd;
            wb_data_o <= half;
        end
    end

    // R8: register 0 is never written.
    p_no_zero_dest_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en_o |-> (wb_idx_o != '0));

    // R9: an illegal instruction never writes back.
    p_illegal_no_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(wb_en_o && illegal_o));

endmodule

// File: rtl/mac_exec_unit.sv
// Module: mac_exec_unit (top)
// Multiply / multiply-accumulate execution unit with a 64-bit accumulator.
// It accepts one instruction per cycle. The accumulator and the writeback
// update on the same edge. Assumes operands arrive with the instruction.
module mac_exec_unit
    import mac_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        valid_i,
    input  logic [31:0] instr_i,
    input  logic [31:0] rs_val_i,
    input  logic [31:0] rt_val_i,
    output logic        wb_en_o,
    output logic [4:0]  wb_idx_o,
    output logic [31:0] wb_data_o,
    output logic        illegal_o,
    output logic [31:0] hi_o,
    output logic [31:0] lo_o
);

    localparam int AW = 2 * XLEN;

    mac_ctrl_t     ctrl;
    logic [AW-1:0] acc_next;
    logic [AW-1:0] acc;

    mac_decode i_decode (
        .valid_i (valid_i),
        .instr_i (instr_i),
        .ctrl_o  (ctrl)
    );

    mac_accum #(.XLEN(XLEN)) i_accum (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_i     (ctrl),
        .a_i        (rs_val_i),
        .b_i        (rt_val_i),
        .acc_next_o (acc_next),
        .acc_o      (acc)
    );

    mac_wb #(.XLEN(XLEN)) i_wb (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_i    (ctrl),
        .acc_i     (acc_next),
        .wb_en_o   (wb_en_o),
        .wb_idx_o  (wb_idx_o),
        .wb_data_o (wb_data_o),
        .illegal_o (illegal_o)
    );

    assign hi_o = acc[AW-1:XLEN];
    assign lo_o = acc[XLEN-1:0];

    // R6: written data is always one half of the accumulator just loaded.
    p_wb_is_half_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en_o |-> (wb_data_o == hi_o || wb_data_o == lo_o));

    // R10: an idle cycle yields no strobes and no accumulator change.
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> (!wb_en_o && !illegal_o && $stable({hi_o, lo_o})));

    // R9: the illegal flag comes with an unchanged accumulator.
    p_illegal_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && instr_i[31:26] == OPC_REG && instr_i[5:0] == FUNCT_MAC
         && instr_i[10:6] == 5'b11111) |=> (illegal_o && $stable({hi_o, lo_o})));

endmodule

// File: tb/test_mac_exec_unit.sv
// Scoreboard bench: the driver computes expected results into a queue and
// the monitor pops and compares them one cycle after each drive.
module test_mac_exec_unit;

    typedef struct {
        logic        en;
        logic [4:0]  idx;
        logic [31:0] data;
        logic        ill;
        logic [63:0] acc;
        string       req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_i = 1'b0;
    logic [31:0] instr_i = '0;
    logic [31:0] rs_val_i = '0;
    logic [31:0] rt_val_i = '0;
    logic        wb_en_o;
    logic [4:0]  wb_idx_o;
    logic [31:0] wb_data_o;
    logic        illegal_o;
    logic [31:0] hi_o;
    logic [31:0] lo_o;

    int          n_checks = 0;
    int          n_errors = 0;
    logic [63:0] model_acc = '0;
    exp_t        exp_q[$];

    always #2.5 clk = ~clk;

    mac_exec_unit i_mac_exec_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid_i   (valid_i),
        .instr_i   (instr_i),
        .rs_val_i  (rs_val_i),
        .rt_val_i  (rt_val_i),
        .wb_en_o   (wb_en_o),
        .wb_idx_o  (wb_idx_o),
        .wb_data_o (wb_data_o),
        .illegal_o (illegal_o),
        .hi_o      (hi_o),
        .lo_o      (lo_o)
    );

    function automatic logic [31:0] mk(input logic [4:0] code, input logic [4:0] rd,
                                       input logic [5:0] fn = 6'b101000,
                                       input logic [5:0] op = 6'b000000);
        return {op, 5'd1, 5'd2, rd, code, fn};
    endfunction

    // Drive one cycle and push the result the requirements predict.
    task automatic issue(input logic v, input logic [31:0] ins, input logic [31:0] a,
                         input logic [31:0] b, input string req);
        exp_t        e;
        logic [4:0]  code;
        logic [4:0]  rd;
        logic [63:0] pa;
        logic [63:0] pb;
        logic [63:0] nxt;
        logic        legal;
        @(negedge clk);
        valid_i  = v;
        instr_i  = ins;
        rs_val_i = a;
        rt_val_i = b;
        code = ins[10:6];
        rd   = ins[15:11];
        e.en = 1'b0; e.idx = rd; e.data = '0; e.ill = 1'b0; e.req = req;
        if (v && ins[31:26] == 6'b0 && ins[5:0] == 6'b101000) begin
            legal = (code == 5'b00000 && rd == 5'd0) ||
                    (code inside {5'b00100, 5'b00101, 5'b01100, 5'b01101,
                                  5'b00010, 5'b00011, 5'b01010, 5'b01011});
            if (legal) begin
                if (code[0] == 1'b0) begin
                    pa = {{32{a[31]}}, a}; pb = {{32{b[31]}}, b};
                end else begin
                    pa = {32'b0, a}; pb = {32'b0, b};
                end
                nxt = pa * pb;
                if (code[2] == 1'b0) nxt = model_acc + nxt;
                model_acc = nxt;
                e.en   = (rd != 5'd0);
                e.data = code[3] ? nxt[63:32] : nxt[31:0];
            end else begin
                e.ill = 1'b1;
            end
        end
        e.acc = model_acc;
        exp_q.push_back(e);
    endtask

    // Monitor: compare outputs shortly after each edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                n_checks++;
                if (wb_en_o !== e.en || illegal_o !== e.ill || {hi_o, lo_o} !== e.acc ||
                    (e.en && (wb_idx_o !== e.idx || wb_data_o !== e.data))) begin
                    n_errors++;
                    $display("FAIL %s: en=%0b idx=%0d data=%h ill=%0b acc=%h | expected en=%0b idx=%0d data=%h ill=%0b acc=%h",
                             e.req, wb_en_o, wb_idx_o, wb_data_o, illegal_o, {hi_o, lo_o},
                             e.en, e.idx, e.data, e.ill, e.acc);
                end
            end
        end
    end

    task automatic check_reset(input string req);
        n_checks++;
        if (hi_o !== 32'd0 || lo_o !== 32'd0 || wb_en_o !== 1'b0 || illegal_o !== 1'b0) begin
            n_errors++;
            $display("FAIL %s: hi=%h lo=%h en=%0b ill=%0b | expected all zero",
                     req, hi_o, lo_o, wb_en_o, illegal_o);
        end
    endtask

    task automatic finish_run();
        $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    endtask

    initial begin
        #100000;
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: run did not complete | expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_reset("R11 after reset");
        rst_n = 1'b1;

        // R2: signed multiply, low and high halves
        issue(1, mk(5'b00100, 5'd5), 32'hFFFF_FFFD, 32'd7, "R2 signed mul lo");
        issue(1, mk(5'b01100, 5'd6), 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R2 R6 signed mul hi");
        // R3: unsigned multiply
        issue(1, mk(5'b01101, 5'd7), 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R3 R6 unsigned mul hi");
        issue(1, mk(5'b00101, 5'd8), 32'h8000_0000, 32'd2, "R3 unsigned mul lo");
        // R4: signed accumulate, low and high
        issue(1, mk(5'b00010, 5'd9), 32'hFFFF_FFFF, 32'd3, "R4 signed mac lo");
        issue(1, mk(5'b01010, 5'd10), 32'h8000_0000, 32'h7FFF_FFFF, "R4 R6 signed mac hi");
        // R5: unsigned accumulate with wrap past 2^64
        issue(1, mk(5'b01101, 5'd11), 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R3 preload");
        issue(1, mk(5'b01011, 5'd12), 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R5 unsigned mac wrap hi");
        issue(1, mk(5'b00011, 5'd13), 32'h1234_5678, 32'h9ABC_DEF0, "R5 unsigned mac lo");
        // R7: plain accumulate, no write
        issue(1, mk(5'b00000, 5'd0), 32'hFFFF_FFF0, 32'd16, "R7 plain accumulate");
        // R8: destination zero suppressed, accumulator still updates
        issue(1, mk(5'b00100, 5'd0), 32'd1000, 32'd1000, "R8 mul to r0");
        issue(1, mk(5'b01010, 5'd0), 32'd5, 32'd5, "R8 mac to r0");
        // R9: illegal codes
        issue(1, mk(5'b00001, 5'd4), 32'd3, 32'd3, "R9 code 00001");
        issue(1, mk(5'b00000, 5'd3), 32'd3, 32'd3, "R9 code 0 with rd");
        issue(1, mk(5'b11111, 5'd2), 32'd3, 32'd3, "R9 code 11111");
        issue(1, mk(5'b00110, 5'd2), 32'd3, 32'd3, "R9 code 00110");
        // R1: non-matching words are ignored
        issue(1, mk(5'b00100, 5'd5, 6'b101001), 32'd9, 32'd9, "R1 other funct");
        issue(1, mk(5'b00100, 5'd5, 6'b101000, 6'b000001), 32'd9, 32'd9, "R1 other opcode");
        // R10: valid low, and strobes last one cycle
        issue(0, mk(5'b00100, 5'd5), 32'd9, 32'd9, "R10 valid low");
        issue(1, mk(5'b00100, 5'd14), 32'd6, 32'd7, "R10 single accept");
        issue(0, 32'd0, 32'd0, 32'd0, "R10 strobe drops");
        issue(1, mk(5'b11110, 5'd14), 32'd6, 32'd7, "R9 R10 illegal pulse");
        issue(0, 32'd0, 32'd0, 32'd0, "R10 illegal drops");
        // back-to-back accumulates
        for (int k = 0; k < 6; k++)
            issue(1, mk(5'b00010, 5'(k + 1)), 32'(k * 37 - 50), 32'(k + 11), "R4 back-to-back");

        // R11: mid-run synchronous reset
        @(negedge clk);
        valid_i = 1'b1;
        instr_i = mk(5'b00100, 5'd9);
        rs_val_i = 32'd4;
        rt_val_i = 32'd4;
        rst_n = 1'b0;
        @(negedge clk);
        check_reset("R11 mid-run reset");
        rst_n = 1'b1;
        valid_i = 1'b0;
        model_acc = '0;
        issue(1, mk(5'b00011, 5'd15), 32'd2, 32'd3, "R11 R5 accumulate from zero");
        @(negedge clk);
        @(negedge clk);
        finish_run();
    end

endmodule